// File: doc/BRIEF.md
# Time-Partitioned Memory Request Scheduler

This block sits in front of a DRAM command generator that is shared by several security domains. Incoming memory requests are sorted into one queue per security domain, so a queue never holds requests from more than one domain. Time is cut into turns that rotate through the domains in a fixed order (0, 1, …, N-1, 0, …). Only the domain that owns the current turn may send a request to the command path. The length of each domain's turn comes from a static per-domain configuration. Demand, queue occupancy and traffic never change the schedule.

Every turn ends with a drain window of a configured number of cycles. No request issues during that window, so work that is already in flight finishes before the next domain's turn begins. The drain is 46 cycles when domains share banks and 8 cycles when banks are partitioned between domains. Each issued request is a complete close-page access: activate, access and precharge. Row state therefore never carries from one turn into the next. The DRAM is modelled only as a fixed service latency, and a completion pulse reports when each issued request finishes. An owner with an empty queue wastes its slot. Another domain may never use it.

The turn controller is a three-state machine:
- **BOOT**: one cycle after reset, in which domain 0's configuration is loaded.
- **ISSUE**: the owner may issue.
- **DRAIN**: no issue.

Its transitions are:
- **load-open** (BOOT→ISSUE) and **load-closed** (BOOT→DRAIN).
- **drain-start** (ISSUE→DRAIN), taken when the counter reaches turn length minus drain length.
- **hold** (ISSUE→ISSUE or DRAIN→DRAIN within a turn).
- **switch-open** and **switch-closed** at a turn boundary. These move to ISSUE or to DRAIN, depending on the newly latched lengths.

Top module: `tp_mem_sched`

## Requirements
- R1: A request is accepted on a clock edge when `req_valid` is high and `req_ready[req_dom]` is high. It enters the queue of domain `req_dom`, and each domain's requests leave in the order they were accepted. `iss_bank`, `iss_row`, `iss_col` and `iss_write` carry the accepted fields unchanged.
- R2: After BOOT, turns rotate through the domains in order, starting with domain 0. A request issues only from the owner of the current turn, and `iss_dom` equals that owner.
- R3: Turn length and drain length are latched at the start of each turn. The turn length is `cfg_turn_len[d*TURN_W +: TURN_W]` for owner d, with a value of 0 treated as 1. The drain length is `cfg_dead`. A configuration change in the middle of a turn takes effect at the next turn boundary.
- R4: With cycle index c (0-based) in a turn of length L and drain length D, an issue may occur only when c + D < L. When D ≥ L, the turn issues nothing.
- R5: At most one request issues per cycle. An owner with a non-empty queue issues in every cycle of its open window.
- R6: When the owner's queue is empty, no request issues in that cycle, even when other domains have pending requests.
- R7: `req_ready[d]` is low exactly when queue d holds QDEPTH entries. A full queue in one domain does not change the issue timing of any other domain.
- R8: `cmp_valid` pulses exactly SVC_LAT cycles after each issue, with `cmp_dom` equal to the issuing domain.
- R9: During reset and in the BOOT cycle that follows it:
  - every queue is empty;
  - all ready bits are high;
  - `iss_valid` and `cmp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_dom | input | DOM_W | Security domain of the request |
| req_bank | input | BANK_W | Bank address |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | NUM_DOM | Per-domain queue not full |
| cfg_turn_len | input | NUM_DOM*TURN_W | Static turn length per domain |
| cfg_dead | input | TURN_W | Drain window length at end of each turn |
| iss_valid | output | 1 | Request issued this cycle |
| iss_dom | output | DOM_W | Domain of issued request |
| iss_bank | output | BANK_W | Bank of issued request |
| iss_row | output | ROW_W | Row of issued request |
| iss_col | output | COL_W | Column of issued request |
| iss_write | output | 1 | Direction of issued request |
| cmp_valid | output | 1 | Issued request completes this cycle |
| cmp_dom | output | DOM_W | Domain of the completing request |

## Verification
The bench sweeps turn lengths of 1 to 5, drain lengths of 0 to 5 and four traffic patterns, and compares every output in every cycle against an arithmetic model.
- **Drain boundary.** A design with an off-by-one at the drain edge would issue in the first drain cycle, or lose the last open cycle.
- **Drain of 0 and drain ≥ length.** One bad comparison would either never close the window or issue in a turn that must stay silent.
- **Turns of length 1.** A design that latched configuration mid-turn, or rotated owners wrongly, would issue from the wrong domain.
- **Idle owner and full queues.** Traffic patterns that starve one domain or fill another's queue expose a design that lends an idle slot to a waiting domain, or that lets backpressure shift another domain's issues.

// File: rtl/tp_pkg.sv
package tp_pkg;
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } turn_state_e;
endpackage

// File: rtl/tp_dom_fifo.sv
module tp_dom_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_q, rd_q;
    logic [CW-1:0]    cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            if (push && !pop)      cnt_q <= cnt_q + CW'(1);
            else if (pop && !push) cnt_q <= cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    always_comb begin
        dout  = mem[rd_q];
        empty = (cnt_q == '0);
        full  = (cnt_q == CW'(DEPTH));
    end
endmodule

// File: rtl/tp_turn_ctrl.sv
module tp_turn_ctrl
    import tp_pkg::*;
#(
    parameter int NUM_DOM = 2,
    parameter int DOM_W   = 1,
    parameter int TURN_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_DOM*TURN_W-1:0]   cfg_len,
    input  logic [TURN_W-1:0]           cfg_dead,
    output turn_state_e                 state,
    output logic [DOM_W-1:0]            owner,
    output logic [TURN_W-1:0]           cnt,
    output logic [TURN_W-1:0]           len,
    output logic [TURN_W-1:0]           dead,
    output logic                        win_open
);
    localparam logic [DOM_W-1:0] LAST_DOM = DOM_W'(NUM_DOM - 1);

    turn_state_e       state_q, state_d;
    logic [DOM_W-1:0]  own_q, own_d;
    logic [TURN_W-1:0] cnt_q, cnt_d, len_q, len_d, dead_q, dead_d;

    function automatic logic [TURN_W-1:0] len_of(input logic [DOM_W-1:0] d);
        logic [TURN_W-1:0] v;
        v = cfg_len[int'(d)*TURN_W +: TURN_W];
        return (v == '0) ? TURN_W'(1) : v;
    endfunction

    function automatic logic opens(input logic [TURN_W-1:0] c,
                                   input logic [TURN_W-1:0] l,
                                   input logic [TURN_W-1:0] d);
        return ({1'b0, c} + {1'b0, d}) < {1'b0, l};
    endfunction

    // Next-state and transition logic
    always_comb begin
        state_d = state_q;
        own_d   = own_q;
        cnt_d   = cnt_q;
        len_d   = len_q;
        dead_d  = dead_q;
        unique case (state_q)
            ST_BOOT: begin
                // load-open / load-closed
                own_d   = '0;
                cnt_d   = '0;
                len_d   = len_of('0);
                dead_d  = cfg_dead;
                state_d = opens('0, len_d, dead_d) ? ST_ISSUE : ST_DRAIN;
            end
            ST_ISSUE, ST_DRAIN: begin
                if (cnt_q == len_q - TURN_W'(1)) begin
                    // switch-open / switch-closed
                    own_d   = (own_q == LAST_DOM) ? '0 : own_q + DOM_W'(1);
                    cnt_d   = '0;
                    len_d   = len_of(own_d);
                    dead_d  = cfg_dead;
                    state_d = opens('0, len_d, dead_d) ? ST_ISSUE : ST_DRAIN;
                end else begin
                    // hold / drain-start
                    cnt_d   = cnt_q + TURN_W'(1);
                    state_d = opens(cnt_d, len_q, dead_q) ? ST_ISSUE : ST_DRAIN;
                end
            end
            default: state_d = ST_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            own_q   <= '0;
            cnt_q   <= '0;
            len_q   <= TURN_W'(1);
            dead_q  <= '0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
            dead_q  <= dead_d;
        end
    end

    // Outputs
    always_comb begin
        state    = state_q;
        owner    = own_q;
        cnt      = cnt_q;
        len      = len_q;
        dead     = dead_q;
        win_open = (state_q == ST_ISSUE);
    end
endmodule

// File: rtl/tp_mem_sched.sv
module tp_mem_sched
    import tp_pkg::*;
#(
    parameter int NUM_DOM = 2,
    parameter int QDEPTH  = 8,
    parameter int BANK_W  = 3,
    parameter int ROW_W   = 14,
    parameter int COL_W   = 10,
    parameter int TURN_W  = 8,
    parameter int SVC_LAT = 8,
    parameter int DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [DOM_W-1:0]          req_dom,
    input  logic [BANK_W-1:0]         req_bank,
    input  logic [ROW_W-1:0]          req_row,
    input  logic [COL_W-1:0]          req_col,
    input  logic                      req_write,
    output logic [NUM_DOM-1:0]        req_ready,
    input  logic [NUM_DOM*TURN_W-1:0] cfg_turn_len,
    input  logic [TURN_W-1:0]         cfg_dead,
    output logic                      iss_valid,
    output logic [DOM_W-1:0]          iss_dom,
    output logic [BANK_W-1:0]         iss_bank,
    output logic [ROW_W-1:0]          iss_row,
    output logic [COL_W-1:0]          iss_col,
    output logic                      iss_write,
    output logic                      cmp_valid,
    output logic [DOM_W-1:0]          cmp_dom
);
    localparam int PAY_W = 1 + BANK_W + ROW_W + COL_W;

    turn_state_e       t_state;
    logic [DOM_W-1:0]  t_owner;
    logic [TURN_W-1:0] t_cnt, t_len, t_dead;
    logic              t_open;

    tp_turn_ctrl #(
        .NUM_DOM(NUM_DOM), .DOM_W(DOM_W), .TURN_W(TURN_W)
    ) u_turn (
        .clk(clk), .rst_n(rst_n),
        .cfg_len(cfg_turn_len), .cfg_dead(cfg_dead),
        .state(t_state), .owner(t_owner), .cnt(t_cnt),
        .len(t_len), .dead(t_dead), .win_open(t_open)
    );

    logic [PAY_W-1:0]   in_pay;
    logic [PAY_W-1:0]   q_head [NUM_DOM];
    logic [NUM_DOM-1:0] q_empty, q_full, q_push, q_pop;
    logic               go;

    assign in_pay = {req_write, req_bank, req_row, req_col};
    assign go     = t_open && !q_empty[t_owner];

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        assign q_push[g] = req_valid && (req_dom == DOM_W'(g)) && !q_full[g];
        assign q_pop[g]  = go && (t_owner == DOM_W'(g));
        tp_dom_fifo #(.WIDTH(PAY_W), .DEPTH(QDEPTH)) u_q (
            .clk(clk), .rst_n(rst_n),
            .push(q_push[g]), .din(in_pay),
            .pop(q_pop[g]), .dout(q_head[g]),
            .empty(q_empty[g]), .full(q_full[g])
        );
    end

    // Fixed service latency model
    logic             pv_q [SVC_LAT];
    logic [DOM_W-1:0] pd_q [SVC_LAT];

    for (genvar s = 0; s < SVC_LAT; s++) begin : g_svc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pv_q[s] <= 1'b0;
                pd_q[s] <= '0;
            end else if (s == 0) begin
                pv_q[s] <= go;
                pd_q[s] <= t_owner;
            end else begin
                pv_q[s] <= pv_q[(s == 0) ? 0 : s-1];
                pd_q[s] <= pd_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    always_comb begin
        req_ready = ~q_full;
        iss_valid = go;
        iss_dom   = t_owner;
        {iss_write, iss_bank, iss_row, iss_col} = q_head[t_owner];
        cmp_valid = pv_q[SVC_LAT-1];
        cmp_dom   = pd_q[SVC_LAT-1];
    end
endmodule

// File: rtl/tp_sched_chk.sv
module tp_sched_chk
    import tp_pkg::*;
#(
    parameter int NUM_DOM = 2,
    parameter int DOM_W   = 1,
    parameter int TURN_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iss_valid,
    input logic [DOM_W-1:0]  iss_dom,
    input turn_state_e       state,
    input logic [DOM_W-1:0]  owner,
    input logic [TURN_W-1:0] cnt,
    input logic [TURN_W-1:0] len,
    input logic [TURN_W-1:0] dead
);
    localparam logic [DOM_W-1:0] LAST_DOM = DOM_W'(NUM_DOM - 1);

    logic at_end;
    assign at_end = (state != ST_BOOT) && (cnt == len - TURN_W'(1));

    assert_issue_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_dom == owner));

    assert_owner_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |=> (owner == (($past(owner) == LAST_DOM) ? '0 : $past(owner) + DOM_W'(1))));

    assert_issue_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (({1'b0, cnt} + {1'b0, dead}) < {1'b0, len}));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_BOOT) |-> (cnt < len));

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_BOOT) && !at_end) |=> ($stable(len) && $stable(dead) && $stable(owner)));

    assert_boot_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT) |=> (state != ST_BOOT));

    assert_boot_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BOOT) |-> !iss_valid);
endmodule

bind tp_mem_sched tp_sched_chk #(
    .NUM_DOM(NUM_DOM), .DOM_W(DOM_W), .TURN_W(TURN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_dom(iss_dom),
    .state(t_state), .owner(t_owner), .cnt(t_cnt),
    .len(t_len), .dead(t_dead)
);

// File: tb/tb_tp_mem_sched.sv
module tb_tp_mem_sched;
    localparam int N      = 2;
    localparam int QD     = 4;
    localparam int BANK_W = 3;
    localparam int ROW_W  = 6;
    localparam int COL_W  = 4;
    localparam int TURN_W = 8;
    localparam int SVC    = 4;
    localparam int DOM_W  = 1;
    localparam int PAY_W  = 1 + BANK_W + ROW_W + COL_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [DOM_W-1:0] req_dom = '0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic req_write = 1'b0;
    logic [N-1:0] req_ready;
    logic [N*TURN_W-1:0] cfg_turn_len = '0;
    logic [TURN_W-1:0] cfg_dead = '0;
    logic iss_valid, iss_write, cmp_valid;
    logic [DOM_W-1:0] iss_dom, cmp_dom;
    logic [BANK_W-1:0] iss_bank;
    logic [ROW_W-1:0] iss_row;
    logic [COL_W-1:0] iss_col;

    always #4 clk = ~clk;

    tp_mem_sched #(
        .NUM_DOM(N), .QDEPTH(QD), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .COL_W(COL_W), .TURN_W(TURN_W), .SVC_LAT(SVC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dom(req_dom),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_write(req_write), .req_ready(req_ready),
        .cfg_turn_len(cfg_turn_len), .cfg_dead(cfg_dead),
        .iss_valid(iss_valid), .iss_dom(iss_dom), .iss_bank(iss_bank),
        .iss_row(iss_row), .iss_col(iss_col), .iss_write(iss_write),
        .cmp_valid(cmp_valid), .cmp_dom(cmp_dom)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    bit m_run;
    int m_own, m_cnt, m_len, m_dead;
    logic [PAY_W-1:0] qbuf [N][QD];
    int qn [N];
    bit pv [SVC];
    int pd [SVC];
    int seq = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle cnt %0d owner %0d)",
                     tag, act, exp, m_cnt, m_own);
        end
    endtask

    function automatic int clamp_len(input int d);
        int v;
        v = int'(cfg_turn_len[d*TURN_W +: TURN_W]);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic model_clear();
        m_run = 0; m_own = 0; m_cnt = 0; m_len = 1; m_dead = 0;
        for (int d = 0; d < N; d++) qn[d] = 0;
        for (int s = 0; s < SVC; s++) begin pv[s] = 0; pd[s] = 0; end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        model_clear();
        repeat (3) @(negedge clk);
        // R9: state while reset is held
        chk(iss_valid == 1'b0, "R9 iss_valid in reset", int'(iss_valid), 0);
        chk(req_ready == {N{1'b1}}, "R9 ready in reset", int'(req_ready), (1 << N) - 1);
        chk(cmp_valid == 1'b0, "R9 cmp_valid in reset", int'(cmp_valid), 0);
        rst_n = 1'b1;
    endtask

    // One cycle: called at a negedge; checks, drives, updates model, returns at next negedge
    task automatic cycle(input bit v, input int dom);
        bit exp_iss;
        logic [PAY_W-1:0] pay, head;
        logic [N-1:0] exp_rdy;
        string tag;
        int pre_n;

        exp_iss = m_run && (m_cnt + m_dead < m_len) && (qn[m_own] > 0);
        if (!m_run)                        tag = "R9 issue in boot";
        else if (m_cnt == 0)               tag = "R3 issue at turn start";
        else if (m_cnt + m_dead >= m_len)  tag = "R4 issue in drain";
        else if (qn[m_own] == 0)           tag = "R6 idle owner slot";
        else                               tag = "R5 issue in open window";
        chk(iss_valid == exp_iss, tag, int'(iss_valid), int'(exp_iss));
        if (exp_iss && iss_valid) begin
            head = qbuf[m_own][0];
            chk(int'(iss_dom) == m_own, "R2 issuing domain", int'(iss_dom), m_own);
            chk({iss_write, iss_bank, iss_row, iss_col} == head, "R1 order and fields",
                int'({iss_write, iss_bank, iss_row, iss_col}), int'(head));
        end
        for (int d = 0; d < N; d++) exp_rdy[d] = (qn[d] < QD);
        chk(req_ready == exp_rdy, "R7 ready", int'(req_ready), int'(exp_rdy));
        chk(cmp_valid == pv[SVC-1], "R8 completion pulse", int'(cmp_valid), int'(pv[SVC-1]));
        if (pv[SVC-1] && cmp_valid)
            chk(int'(cmp_dom) == pd[SVC-1], "R8 completion domain", int'(cmp_dom), pd[SVC-1]);

        // drive
        seq++;
        pay = PAY_W'(seq * 37 + dom);
        req_valid = v;
        req_dom = DOM_W'(dom);
        {req_write, req_bank, req_row, req_col} = pay;

        // model update
        pre_n = qn[dom];
        for (int s = SVC - 1; s > 0; s--) begin pv[s] = pv[s-1]; pd[s] = pd[s-1]; end
        pv[0] = exp_iss;
        pd[0] = m_own;
        if (exp_iss) begin
            for (int i = 0; i < QD - 1; i++) qbuf[m_own][i] = qbuf[m_own][i+1];
            qn[m_own]--;
        end
        if (v && pre_n < QD) begin
            qbuf[dom][qn[dom]] = pay;
            qn[dom]++;
        end
        if (!m_run) begin
            m_run = 1; m_own = 0; m_cnt = 0;
            m_len = clamp_len(0); m_dead = int'(cfg_dead);
        end else if (m_cnt == m_len - 1) begin
            m_own = (m_own + 1) % N; m_cnt = 0;
            m_len = clamp_len(m_own); m_dead = int'(cfg_dead);
        end else begin
            m_cnt++;
        end
        @(negedge clk);
    endtask

    task automatic run(input int pat, input int cycles);
        bit v;
        int d;
        for (int t = 0; t < cycles; t++) begin
            case (pat)
                0: begin v = 1; d = t % 2; end
                1: begin v = 1; d = 0; end                  // domain 1 idle (R6)
                2: begin v = 1; d = (t % 4 == 0) ? 0 : 1; end // domain 1 saturates (R7)
                default: begin v = ((t % 7) < 3); d = (t / 2) % 2; end
            endcase
            cycle(v, d);
        end
    endtask

    initial begin
        @(negedge clk);
        cfg_turn_len = {TURN_W'(4), TURN_W'(6)};
        cfg_dead = TURN_W'(2);
        do_reset();
        run(0, 120);
        // sweep: configuration changes land mid-turn and must wait for a boundary (R3)
        for (int l0 = 0; l0 <= 5; l0++) begin
            for (int li = 0; li < 2; li++) begin
                for (int dd = 0; dd <= 5; dd++) begin
                    for (int p = 0; p < 4; p++) begin
                        cfg_turn_len = {TURN_W'((li == 0) ? 1 : 4), TURN_W'(l0)};
                        cfg_dead = TURN_W'(dd);
                        run(p, 25);
                    end
                end
            end
        end
        // default 64-cycle turns with partitioned-bank and shared-bank drains
        cfg_turn_len = {TURN_W'(64), TURN_W'(64)};
        cfg_dead = TURN_W'(8);
        do_reset();
        run(0, 300);
        run(2, 200);
        cfg_dead = TURN_W'(46);
        run(3, 300);
        cfg_turn_len = {TURN_W'(100), TURN_W'(64)};
        run(0, 400);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule